// File: doc/BRIEF.md
# Shutter Step Controller with Auto-Iris

This block holds the exposure setting of a sensor's electronic shutter as a step index from 0 to 255. Step 0 is the slowest shutter, one full field (1/60 s on the 525-line standard, 1/50 s on the 625-line standard). Higher steps give shorter exposures. The active step is set by one of three sources. A three-wire serial loader takes a data line, a shift clock and a strobe. A 3-bit parallel code selects one of eight preset speeds. An auto-iris counter moves one step per field under two comparator flags. A standard-select input chooses the 525-line or the 625-line step tables.

In auto-iris mode the counter is held inside a window. The lower bound is either step 0 or a low-speed limit. The upper bound is picked from four choices by the two high-speed limit pins. A rising edge on the power-on input loads the 1/1000 s step. When the enable input is low, the shutter is off: the reported step is 0 and the discharge-pulse enable is low. The discharge pulse itself is produced elsewhere from the step and the enable reported here.

All asynchronous serial lines and the power-on input are synchronized to `clk`. The field tick is assumed to be a one-cycle pulse that is already synchronous to `clk`. The outputs are registered.

Top module: `shutter_step_ctrl`

## Requirements
- R1: After reset, `step_o` is 0 and `discharge_en_o` is 0.
- R2: While `enable` is low, `step_o` is 0 and `discharge_en_o` is 0 from the next cycle on. While `enable` is high, `discharge_en_o` is 1.
- R3: In serial mode (`enable`=1, `iris_mode`=0, `par_mode`=0), `ser_dat` is shifted in on each rising edge of `ser_clk`, most significant bit first. On a rising edge of `ser_stb`, the last eight bits become the word W, and the step becomes 255 minus W (so 8'hFF gives step 0, 8'hF6 gives step 9 and 8'h00 gives step 255).
- R4: Shifting serial bits without a strobe leaves `step_o` unchanged.
- R5: In parallel mode (`enable`=1, `iris_mode`=0, `par_mode`=1), the preset is indexed by k = 7 − `par_code`. For k = 0..7 the step is 9, 26, 45, 61, 71, 87, 100, 149 on the 525-line standard (`std_625`=0). On the 625-line standard (`std_625`=1) it is 14, 28, 47, 63, 72, 89, 103, 151.
- R6: In iris mode (`enable`=1, `iris_mode`=1), each `field_tick` with only `up_flag` set raises the step by one, and each tick with only `dn_flag` set lowers it by one. A tick with both flags or with neither flag leaves an in-range step unchanged. Without a tick, the step does not move.
- R7: The iris upper bound is selected by `hi_limit`. For 2'b00 it is 149 (525-line) or 151 (625-line). For 2'b10 it is 125 or 130. For 2'b11 it is 100 or 103. For 2'b01 it is 87 or 89.
- R8: The iris lower bound is 0 when `lo_limit` is 0. When `lo_limit` is 1 it is 9 (525-line) or 14 (625-line).
- R9: In iris mode, a low-to-high transition of `pwr_on` loads step 61 (525-line) or 63 (625-line).
- R10: On a field tick, an iris step that lies outside the current bounds is moved to the nearest bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_625 | input | 1 | 0: 525-line step tables; 1: 625-line step tables |
| enable | input | 1 | 1: shutter active; 0: shutter off, discharge disabled |
| iris_mode | input | 1 | 1: auto-iris counter; 0: manual setting |
| par_mode | input | 1 | Manual source: 1 parallel preset, 0 serial word |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first (asynchronous) |
| ser_stb | input | 1 | Serial strobe; rising edge applies the word (asynchronous) |
| par_code | input | 3 | Parallel preset code |
| up_flag | input | 1 | Iris comparator: image too bright, go faster |
| dn_flag | input | 1 | Iris comparator: image too dark, go slower |
| field_tick | input | 1 | One-cycle pulse once per field |
| lo_limit | input | 1 | Enables the iris low-speed limit |
| hi_limit | input | 2 | Iris high-speed limit select |
| pwr_on | input | 1 | Power-on initialisation input (asynchronous) |
| step_o | output | 8 | Active shutter step index |
| discharge_en_o | output | 1 | Enables the sensor discharge pulse |

## Verification
A corrupted iris counter appears at `step_o` two cycles after the field tick that moved it. It also stays there, because nothing but a tick or a power-on edge moves the counter. Saturation runs in every bound combination would expose a wrong bound as a step one past the limit. A serial shift register that is loaded on the wrong edge, or in the wrong bit order, only shows after the strobe. The value then reads as a bit-reversed or bit-shifted step. A strobe that is decoded too early shows as a change in `step_o` while bits are still being shifted.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    localparam int STEP_W = 8;
    localparam int CODE_W = 3;

    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic [1:0] {
        SRC_OFF    = 2'd0,
        SRC_SERIAL = 2'd1,
        SRC_PRESET = 2'd2,
        SRC_IRIS   = 2'd3
    } src_e;

    // Preset speeds, slowest (k=0) to fastest (k=7); code value 7 is slowest.
    function automatic step_t preset_step(input logic pal, input logic [CODE_W-1:0] code);
        logic [CODE_W-1:0] k;
        step_t s;
        k = ~code;
        case (k)
            3'd0:    s = pal ? step_t'(14)  : step_t'(9);
            3'd1:    s = pal ? step_t'(28)  : step_t'(26);
            3'd2:    s = pal ? step_t'(47)  : step_t'(45);
            3'd3:    s = pal ? step_t'(63)  : step_t'(61);
            3'd4:    s = pal ? step_t'(72)  : step_t'(71);
            3'd5:    s = pal ? step_t'(89)  : step_t'(87);
            3'd6:    s = pal ? step_t'(103) : step_t'(100);
            default: s = pal ? step_t'(151) : step_t'(149);
        endcase
        return s;
    endfunction

    function automatic step_t iris_hi_bound(input logic pal, input logic [1:0] sel);
        step_t s;
        case (sel)
            2'b00:   s = pal ? step_t'(151) : step_t'(149);
            2'b10:   s = pal ? step_t'(130) : step_t'(125);
            2'b11:   s = pal ? step_t'(103) : step_t'(100);
            default: s = pal ? step_t'(89)  : step_t'(87);
        endcase
        return s;
    endfunction

    function automatic step_t iris_lo_bound(input logic pal, input logic lim);
        step_t s;
        if (!lim)     s = '0;
        else if (pal) s = step_t'(14);
        else          s = step_t'(9);
        return s;
    endfunction

    function automatic step_t iris_init_step(input logic pal);
        return pal ? step_t'(63) : step_t'(61);
    endfunction

endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[LAST];

endmodule

// File: rtl/ssc_serial_rx.sv
module ssc_serial_rx
    import ssc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  active,
    input  logic  ser_clk,
    input  logic  ser_dat,
    input  logic  ser_stb,
    output step_t step_o
);
    typedef struct packed {
        step_t shift;
        step_t word;
        logic  clk_prev;
        logic  stb_prev;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic clk_s, dat_s, stb_s;
    logic clk_rise, stb_rise;

    ssc_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (.clk(clk), .rst_n(rst_n), .din(ser_clk), .dout(clk_s));
    ssc_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (.clk(clk), .rst_n(rst_n), .din(ser_dat), .dout(dat_s));
    ssc_sync #(.STAGES(SYNC_STAGES)) u_sync_stb (.clk(clk), .rst_n(rst_n), .din(ser_stb), .dout(stb_s));

    assign clk_rise = clk_s & ~st_q.clk_prev;
    assign stb_rise = stb_s & ~st_q.stb_prev;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = clk_s;
        st_d.stb_prev = stb_s;
        if (active && clk_rise) st_d.shift = {st_q.shift[STEP_W-2:0], dat_s};
        if (active && stb_rise) st_d.word  = st_q.shift;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shift    <= '0;
            st_q.word     <= '1;
            st_q.clk_prev <= 1'b0;
            st_q.stb_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // Word is complement-coded: all ones means step 0.
    assign step_o = ~st_q.word;

    AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && stb_rise) |=> $stable(st_q.word)); // R4

endmodule

// File: rtl/ssc_iris_ctr.sv
module ssc_iris_ctr
    import ssc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  tick,
    input  logic  up,
    input  logic  dn,
    input  logic  pwr_rise,
    input  step_t lo_bound,
    input  step_t hi_bound,
    input  step_t init_step,
    output step_t step_o
);
    typedef struct packed {
        step_t step;
    } iris_state_t;

    iris_state_t st_d, st_q;
    logic [STEP_W:0] cand;

    always_comb begin
        st_d = st_q;
        cand = {1'b0, st_q.step};
        if (up && !dn)                    cand = {1'b0, st_q.step} + 1'b1;
        else if (dn && !up && st_q.step != '0) cand = {1'b0, st_q.step} - 1'b1;

        if (run && pwr_rise) begin
            st_d.step = init_step;
        end else if (run && tick) begin
            if (cand > {1'b0, hi_bound})      st_d.step = hi_bound;
            else if (cand < {1'b0, lo_bound}) st_d.step = lo_bound;
            else                              st_d.step = cand[STEP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.step <= '0;
        else        st_q      <= st_d;
    end

    assign step_o = st_q.step;

    AST_IRIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && (tick || pwr_rise)) |=> $stable(st_q.step)); // R6

    AST_IRIS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !pwr_rise) |=>
        (st_q.step <= $past(hi_bound) && st_q.step >= $past(lo_bound))); // R7

    AST_IRIS_POWER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pwr_rise) |=> (st_q.step == $past(init_step))); // R9

endmodule

// File: rtl/shutter_step_ctrl.sv
module shutter_step_ctrl
    import ssc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  std_625,
    input  logic                  enable,
    input  logic                  iris_mode,
    input  logic                  par_mode,
    input  logic                  ser_clk,
    input  logic                  ser_dat,
    input  logic                  ser_stb,
    input  logic [CODE_W-1:0]     par_code,
    input  logic                  up_flag,
    input  logic                  dn_flag,
    input  logic                  field_tick,
    input  logic                  lo_limit,
    input  logic [1:0]            hi_limit,
    input  logic                  pwr_on,
    output logic [STEP_W-1:0]     step_o,
    output logic                  discharge_en_o
);
    typedef struct packed {
        step_t out;
        logic  dis;
        logic  pwr_prev;
    } top_state_t;

    top_state_t st_d, st_q;
    src_e  src;
    step_t ser_step, iris_step, preset;
    step_t lo_b, hi_b, init_b;
    logic  pwr_s, pwr_rise;
    logic  iris_run, ser_active;

    assign iris_run   = enable & iris_mode;
    assign ser_active = enable & ~iris_mode & ~par_mode;

    ssc_sync #(.STAGES(SYNC_STAGES)) u_sync_pwr (
        .clk(clk), .rst_n(rst_n), .din(pwr_on), .dout(pwr_s));
    assign pwr_rise = pwr_s & ~st_q.pwr_prev;

    always_comb begin
        lo_b   = iris_lo_bound(std_625, lo_limit);
        hi_b   = iris_hi_bound(std_625, hi_limit);
        init_b = iris_init_step(std_625);
        preset = preset_step(std_625, par_code);
    end

    ssc_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_serial (
        .clk(clk), .rst_n(rst_n), .active(ser_active),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_stb(ser_stb),
        .step_o(ser_step));

    ssc_iris_ctr u_iris (
        .clk(clk), .rst_n(rst_n), .run(iris_run), .tick(field_tick),
        .up(up_flag), .dn(dn_flag), .pwr_rise(pwr_rise),
        .lo_bound(lo_b), .hi_bound(hi_b), .init_step(init_b),
        .step_o(iris_step));

    always_comb begin
        if (!enable)        src = SRC_OFF;
        else if (iris_mode) src = SRC_IRIS;
        else if (par_mode)  src = SRC_PRESET;
        else                src = SRC_SERIAL;
    end

    always_comb begin
        st_d          = st_q;
        st_d.pwr_prev = pwr_s;
        st_d.dis      = enable;
        case (src)
            SRC_IRIS:   st_d.out = iris_step;
            SRC_PRESET: st_d.out = preset;
            SRC_SERIAL: st_d.out = ser_step;
            default:    st_d.out = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.out      <= '0;
            st_q.dis      <= 1'b0;
            st_q.pwr_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign step_o         = st_q.out;
    assign discharge_en_o = st_q.dis;

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (step_o == '0 && !discharge_en_o)); // R2

    AST_DISCHARGE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> discharge_en_o); // R2

endmodule

// File: tb/shutter_step_ctrl_test.sv
module shutter_step_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic std_625 = 0, enable = 0, iris_mode = 0, par_mode = 0;
    logic ser_clk = 0, ser_dat = 0, ser_stb = 0;
    logic [2:0] par_code = 0;
    logic up_flag = 0, dn_flag = 0, field_tick = 0, lo_limit = 0, pwr_on = 0;
    logic [1:0] hi_limit = 0;
    logic [7:0] step_o;
    logic discharge_en_o;

    int n_run = 0, n_fail = 0;
    int exp_step;

    always #(CLK_PERIOD/2) clk = ~clk;

    shutter_step_ctrl uut (
        .clk(clk), .rst_n(rst_n), .std_625(std_625), .enable(enable),
        .iris_mode(iris_mode), .par_mode(par_mode), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .ser_stb(ser_stb), .par_code(par_code),
        .up_flag(up_flag), .dn_flag(dn_flag), .field_tick(field_tick),
        .lo_limit(lo_limit), .hi_limit(hi_limit), .pwr_on(pwr_on),
        .step_o(step_o), .discharge_en_o(discharge_en_o));

    function automatic int exp_preset(input int pal, input int code);
        int k;
        k = 7 - code;
        case (k)
            0: return pal ? 14 : 9;
            1: return pal ? 28 : 26;
            2: return pal ? 47 : 45;
            3: return pal ? 63 : 61;
            4: return pal ? 72 : 71;
            5: return pal ? 89 : 87;
            6: return pal ? 103 : 100;
            default: return pal ? 151 : 149;
        endcase
    endfunction

    function automatic int exp_hi(input int pal, input int sel);
        case (sel)
            0: return pal ? 151 : 149;
            2: return pal ? 130 : 125;
            3: return pal ? 103 : 100;
            default: return pal ? 89 : 87;
        endcase
    endfunction

    function automatic int exp_lo(input int pal, input int lim);
        return lim == 0 ? 0 : (pal ? 14 : 9);
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int got, input int expv);
        n_run++;
        if (got != expv) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    task automatic send_bits(input logic [7:0] w);
        for (int i = 7; i >= 0; i--) begin
            ser_dat = w[i];
            wait_cyc(4);
            ser_clk = 1'b1;
            wait_cyc(4);
            ser_clk = 1'b0;
        end
        wait_cyc(6);
    endtask

    task automatic strobe;
        ser_stb = 1'b1;
        wait_cyc(4);
        ser_stb = 1'b0;
        wait_cyc(6);
    endtask

    task automatic field(input logic u, input logic d, input int n);
        up_flag = u;
        dn_flag = d;
        for (int i = 0; i < n; i++) begin
            field_tick = 1'b1;
            wait_cyc(1);
            field_tick = 1'b0;
            wait_cyc(1);
        end
        up_flag = 0;
        dn_flag = 0;
        wait_cyc(3);
    endtask

    task automatic power_pulse;
        pwr_on = 1'b1;
        wait_cyc(8);
        pwr_on = 1'b0;
        wait_cyc(4);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(3);
        check("R1 step", step_o, 0);
        check("R1 discharge", discharge_en_o, 0);
        rst_n = 1'b1;
        wait_cyc(2);

        // R5 parallel preset sweep, both standards
        enable = 1; par_mode = 1;
        wait_cyc(3);
        check("R2 discharge on", discharge_en_o, 1);
        for (int p = 0; p < 2; p++) begin
            for (int c = 0; c < 8; c++) begin
                std_625 = p[0];
                par_code = c[2:0];
                wait_cyc(3);
                check("R5 preset", step_o, exp_preset(p, c));
            end
        end

        // R3/R4 serial words
        par_mode = 0;
        std_625 = 0;
        wait_cyc(3);
        check("R3 serial idle", step_o, 0);
        exp_step = 0;
        foreach (uut.st_q.out[i]) begin end
        begin
            logic [7:0] words [6];
            words = '{8'hFF, 8'hF6, 8'h00, 8'hA5, 8'h3C, 8'hC2};
            for (int i = 0; i < 6; i++) begin
                send_bits(words[i]);
                check("R4 no strobe hold", step_o, exp_step);
                strobe();
                exp_step = 255 - int'(words[i]);
                check("R3 serial word", step_o, exp_step);
            end
        end

        // R2 disable
        enable = 0;
        wait_cyc(3);
        check("R2 off step", step_o, 0);
        check("R2 off discharge", discharge_en_o, 0);
        enable = 1;

        // Iris sweeps
        iris_mode = 1;
        for (int p = 0; p < 2; p++) begin
            for (int h = 0; h < 4; h++) begin
                int init;
                std_625 = p[0];
                hi_limit = h[1:0];
                lo_limit = 0;
                init = p ? 63 : 61;
                power_pulse();
                check("R9 power-on load", step_o, init);
                field(1, 0, 1);
                check("R6 up one", step_o, init + 1);
                field(1, 1, 1);
                check("R6 both hold", step_o, init + 1);
                field(0, 0, 1);
                check("R6 none hold", step_o, init + 1);
                field(0, 1, 1);
                check("R6 down one", step_o, init);
                wait_cyc(5);
                check("R6 no tick hold", step_o, init);
                field(1, 0, 200);
                check("R7 upper bound", step_o, exp_hi(p, h));
                lo_limit = 1;
                field(0, 1, 200);
                check("R8 lower bound on", step_o, exp_lo(p, 1));
                lo_limit = 0;
                field(0, 1, 30);
                check("R8 lower bound off", step_o, 0);
            end
        end

        // R10 out-of-window correction
        std_625 = 0;
        hi_limit = 2'b00;
        field(1, 0, 200);
        check("R7 full range", step_o, 149);
        hi_limit = 2'b11;
        wait_cyc(3);
        check("R10 no tick yet", step_o, 149);
        field(0, 0, 1);
        check("R10 pulled to upper", step_o, 100);
        field(0, 1, 120);
        check("R10 at zero", step_o, 0);
        lo_limit = 1;
        field(0, 0, 1);
        check("R10 pulled to lower", step_o, 9);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule